// File: doc/BRIEF.md
# Microcoded Transfer Processing Element

This block runs a stored list of microcommands. Each command names one explicit transfer or operation: a move between buffers and registers, a load of an ALU argument latch, a capture of the ALU result, a drive of the attached memory port's address or write data, or a capture of that port's read data. Commands are grouped into bundles that stand for one clock cycle of the scheduled algorithm. Every command inside a bundle reads the state as it stood when the bundle opened. All of the bundle's writes land together when the closing marker is reached.

The program memory sits outside the block. The element presents `prog_addr`, and the program memory returns the addressed word on `prog_word` in the same cycle. One word is consumed per clock. A compare command sets a single flag, and a jump can be made conditional on that flag. A wait command stalls the program counter until a free-running step counter reaches a given value. Control is a three-state machine. In ST_OUTSIDE the element is between bundles: an open marker takes it to ST_BUNDLE, and a wait that is not yet satisfied takes it to ST_HOLD. In ST_BUNDLE commands are staged, and the close marker commits them and returns to ST_OUTSIDE. In ST_HOLD the element stays put until the step counter is reached, then returns to ST_OUTSIDE.

Top module: `mpe_core`

## Requirements
- R1: While reset is high, and on the first clock after it is released, the program address is 0. All buffers, registers, argument latches, the result latch and the memory address and data latches are 0. The compare flag is clear and no memory write is issued.
- R2: A program word is {cmd[4:0], pa[15:0], pb[15:0], pc[15:0]}, with cmd in the top bits. The pc field is unused. The cmd codes are: 1 open, 2 close, 3 set-constant, 4 buf→reg, 5 reg→buf, 6 buf→buf, 7 result→buf, 8 buf→arg1, 9 buf→arg2, 10 buf→mem address, 11 buf→mem write data, 12 mem read data→buf, 13 nop, 14 add, 15 sub, 16 mul, 17 cmp-equal, 18 cmp-greater-or-equal, 19 cmp-less-or-equal, 20 jump, 21 wait. Any other code is skipped.
- R3: Inside a bundle, every command reads the committed state as it was before the bundle. All staged writes take effect together on the clock that consumes the close marker. Two buffer-to-buffer moves in one bundle therefore swap two buffers.
- R4: The move commands use pa as the source index and pb as the destination index. They cover buffer to register, register to buffer, buffer to buffer, and result to buffer (pb only).
- R5: Set-constant loads the unsigned value pb into buffer pa.
- R6: Add, sub and mul combine arg1 and arg2 into the result latch. Sub is arg1 minus arg2. Mul keeps the low DW bits of the product. Nop leaves the result unchanged.
- R7: Buf→mem address and buf→mem write data take their source from buffer pa. A bundle that holds a write-data command raises `mem_we` for exactly one cycle, the cycle after its close marker, with the committed address and data. Mem read data→buf captures `mem_rdata` for the committed address into buffer pb.
- R8: The compare commands set the flag to the result of buffer pa ==, >= or <= the unsigned value pb. The flag is visible on `cmp_flag` after the bundle commits.
- R9: A jump to index pa is taken when pb bit 0 is 1, or when the flag as committed before the bundle is set. Inside a bundle, the jump takes effect at the close marker. Outside a bundle, it takes effect at once.
- R10: The step counter is 0 on the first clock after reset and counts up every clock. A wait word outside a bundle holds the program address until a clock on which the counter is ≥ pa, and then advances by one.
- R11: Outside a bundle, every word other than open, jump and wait is skipped with no effect on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_addr | output | PAW | Program counter, index of the word being consumed |
| prog_word | input | 5+3*DW | Program word at `prog_addr`, returned in the same cycle |
| mem_addr | output | DW | Committed memory port address |
| mem_wdata | output | DW | Committed memory port write data |
| mem_we | output | 1 | One-cycle write strobe after a bundle that wrote data |
| mem_rdata | input | DW | Read data of the port for `mem_addr`, returned in the same cycle |
| cmp_flag | output | 1 | Committed compare flag |

## Verification
The embedded properties assume that the program memory returns the word for `prog_addr` combinationally. They also assume that buffer and register indexes fall within the bank sizes, which are powers of two, and that a wait word stays in place while it is held. The stimulus is one fixed program built from those codes alone: indexes stay below eight and every jump target lands on an open marker or a wait word. Results come out through memory writes, which a scoreboard matches against expected address, data and flag values, plus one expected write cycle that tests the wait timing.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_SKIP   = 5'd0,
        OP_OPEN   = 5'd1,
        OP_CLOSE  = 5'd2,
        OP_SETC   = 5'd3,
        OP_B2R    = 5'd4,
        OP_R2B    = 5'd5,
        OP_B2B    = 5'd6,
        OP_RES2B  = 5'd7,
        OP_B2A1   = 5'd8,
        OP_B2A2   = 5'd9,
        OP_B2MA   = 5'd10,
        OP_B2MD   = 5'd11,
        OP_MR2B   = 5'd12,
        OP_XNOP   = 5'd13,
        OP_XADD   = 5'd14,
        OP_XSUB   = 5'd15,
        OP_XMUL   = 5'd16,
        OP_CMPEQ  = 5'd17,
        OP_CMPGE  = 5'd18,
        OP_CMPLE  = 5'd19,
        OP_JUMP   = 5'd20,
        OP_WAIT   = 5'd21
    } op_e;

    typedef enum logic [1:0] {
        ST_OUTSIDE = 2'd0,
        ST_BUNDLE  = 2'd1,
        ST_HOLD    = 2'd2
    } st_e;
endpackage

// File: rtl/mpe_alu.sv
module mpe_alu
    import mpe_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] prev,
    output logic [DW-1:0] y
);
    always_comb begin
        case (op)
            OP_XADD: y = a + b;
            OP_XSUB: y = a - b;
            OP_XMUL: y = a * b;   // context width DW keeps the low bits
            default: y = prev;
        endcase
    end
endmodule

// File: rtl/mpe_seq.sv
module mpe_seq
    import mpe_pkg::*;
#(
    parameter int PAW = 8,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  op_e            op,
    input  logic [PAW-1:0] tgt,
    input  logic           uncond,
    input  logic [CW-1:0]  wait_val,
    input  logic           flag,
    output logic [PAW-1:0] pc,
    output logic           stage_en,
    output logic           commit
);
    st_e            state, state_n;
    logic [PAW-1:0] pc_n, jtgt, jtgt_n;
    logic           jpend, jpend_n;
    logic [CW-1:0]  step_cnt;
    logic           step_ok, take;

    assign step_ok = (step_cnt >= wait_val);
    assign take    = uncond | flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_OUTSIDE;
            pc       <= '0;
            jpend    <= 1'b0;
            jtgt     <= '0;
            step_cnt <= '0;
        end else begin
            state    <= state_n;
            pc       <= pc_n;
            jpend    <= jpend_n;
            jtgt     <= jtgt_n;
            step_cnt <= step_cnt + 1'b1;
        end
    end

    always_comb begin
        state_n  = state;
        pc_n     = pc;
        jpend_n  = jpend;
        jtgt_n   = jtgt;
        stage_en = 1'b0;
        commit   = 1'b0;
        unique case (state)
            ST_OUTSIDE: begin
                case (op)
                    OP_OPEN: begin
                        state_n = ST_BUNDLE;
                        jpend_n = 1'b0;
                        pc_n    = pc + 1'b1;
                    end
                    OP_JUMP: pc_n = take ? tgt : pc + 1'b1;
                    OP_WAIT: begin
                        if (step_ok) pc_n = pc + 1'b1;
                        else         state_n = ST_HOLD;
                    end
                    default: pc_n = pc + 1'b1;
                endcase
            end
            ST_BUNDLE: begin
                if (op == OP_CLOSE) begin
                    commit  = 1'b1;
                    state_n = ST_OUTSIDE;
                    pc_n    = jpend ? jtgt : pc + 1'b1;
                end else if (op == OP_JUMP) begin
                    if (take) begin
                        jpend_n = 1'b1;
                        jtgt_n  = tgt;
                    end
                    pc_n = pc + 1'b1;
                end else begin
                    stage_en = (op != OP_OPEN);
                    pc_n     = pc + 1'b1;
                end
            end
            ST_HOLD: begin
                if (op != OP_WAIT) begin
                    state_n = ST_OUTSIDE;
                end else if (step_ok) begin
                    state_n = ST_OUTSIDE;
                    pc_n    = pc + 1'b1;
                end
            end
            default: state_n = ST_OUTSIDE;
        endcase
    end

    AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && op == OP_WAIT && !step_ok) |=> $stable(pc)); // R10

    AST_PC_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0)); // R1
endmodule

// File: rtl/mpe_core.sv
module mpe_core
    import mpe_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NBUF = 8,
    parameter int NREG = 8,
    parameter int PAW  = 8,
    parameter int CW   = 16,
    parameter int IW   = OPW + 3 * DW
) (
    input  logic           clk,
    input  logic           rst,
    output logic [PAW-1:0] prog_addr,
    input  logic [IW-1:0]  prog_word,
    output logic [DW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           mem_we,
    input  logic [DW-1:0]  mem_rdata,
    output logic           cmp_flag
);
    localparam int BIW = $clog2(NBUF);
    localparam int RIW = $clog2(NREG);

    op_e           op;
    logic [DW-1:0] pa, pb, unused_pc;
    logic [BIW-1:0] pa_b, pb_b;
    logic [RIW-1:0] pa_r, pb_r;

    assign op        = op_e'(prog_word[IW-1 -: OPW]);
    assign pa        = prog_word[3*DW-1 -: DW];
    assign pb        = prog_word[2*DW-1 -: DW];
    assign unused_pc = prog_word[DW-1:0];
    assign pa_b      = pa[BIW-1:0];
    assign pb_b      = pb[BIW-1:0];
    assign pa_r      = pa[RIW-1:0];
    assign pb_r      = pb[RIW-1:0];

    // committed (_q) and staged (_n) copies of every storage element
    logic [DW-1:0] buf_q [NBUF];
    logic [DW-1:0] buf_n [NBUF];
    logic [DW-1:0] reg_q [NREG];
    logic [DW-1:0] reg_n [NREG];
    logic [DW-1:0] a1_q, a1_n, a2_q, a2_n, res_q, res_n;
    logic [DW-1:0] madr_q, madr_n, mdat_q, mdat_n;
    logic          flag_q, flag_n, wpend, we_q;
    logic          stage_en, commit, cmp_hit;
    logic [DW-1:0] alu_y, src_buf;

    assign src_buf = buf_q[pa_b];

    mpe_seq #(.PAW(PAW), .CW(CW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .tgt      (pa[PAW-1:0]),
        .uncond   (pb[0]),
        .wait_val (pa[CW-1:0]),
        .flag     (flag_q),
        .pc       (prog_addr),
        .stage_en (stage_en),
        .commit   (commit)
    );

    mpe_alu #(.DW(DW)) u_alu (
        .op   (op),
        .a    (a1_q),
        .b    (a2_q),
        .prev (res_q),
        .y    (alu_y)
    );

    always_comb begin
        case (op)
            OP_CMPEQ: cmp_hit = (src_buf == pb);
            OP_CMPGE: cmp_hit = (src_buf >= pb);
            OP_CMPLE: cmp_hit = (src_buf <= pb);
            default:  cmp_hit = flag_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBUF; i++) begin
                buf_q[i] <= '0;
                buf_n[i] <= '0;
            end
            for (int i = 0; i < NREG; i++) begin
                reg_q[i] <= '0;
                reg_n[i] <= '0;
            end
            {a1_q, a1_n, a2_q, a2_n, res_q, res_n} <= '0;
            {madr_q, madr_n, mdat_q, mdat_n}       <= '0;
            {flag_q, flag_n, wpend, we_q}          <= '0;
        end else begin
            we_q <= 1'b0;
            if (commit) begin
                buf_q  <= buf_n;
                reg_q  <= reg_n;
                a1_q   <= a1_n;
                a2_q   <= a2_n;
                res_q  <= res_n;
                madr_q <= madr_n;
                mdat_q <= mdat_n;
                flag_q <= flag_n;
                we_q   <= wpend;
                wpend  <= 1'b0;
            end
            if (stage_en) begin
                case (op)
                    OP_SETC:  buf_n[pa_b] <= pb;
                    OP_B2R:   reg_n[pb_r] <= src_buf;
                    OP_R2B:   buf_n[pb_b] <= reg_q[pa_r];
                    OP_B2B:   buf_n[pb_b] <= src_buf;
                    OP_RES2B: buf_n[pb_b] <= res_q;
                    OP_B2A1:  a1_n        <= src_buf;
                    OP_B2A2:  a2_n        <= src_buf;
                    OP_B2MA:  madr_n      <= src_buf;
                    OP_B2MD: begin
                        mdat_n <= src_buf;
                        wpend  <= 1'b1;
                    end
                    OP_MR2B:  buf_n[pb_b] <= mem_rdata;
                    OP_XNOP, OP_XADD, OP_XSUB, OP_XMUL: res_n <= alu_y;
                    OP_CMPEQ, OP_CMPGE, OP_CMPLE:       flag_n <= cmp_hit;
                    default: ;
                endcase
            end
        end
    end

    assign mem_addr  = madr_q;
    assign mem_wdata = mdat_q;
    assign mem_we    = we_q;
    assign cmp_flag  = flag_q;

    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we); // R7

    AST_FROZEN_BETWEEN_COMMITS: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(flag_q) && $stable(madr_q) && $stable(mdat_q) && $stable(res_q))); // R3

    AST_WE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !commit |=> !mem_we); // R7
endmodule

// File: tb/mpe_core_test.sv
module mpe_core_test;
    localparam int OB = 1, OC = 2, SC = 3, BR = 4, RB = 5, BB = 6, RS = 7;
    localparam int A1 = 8, A2 = 9, MA = 10, MD = 11, MR = 12, XA = 14, XS = 15, XM = 16;
    localparam int CE = 17, CG = 18, CL = 19, JP = 20, WT = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  prog_addr;
    logic [52:0] prog_word;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, cmp_flag;

    logic [52:0] rom [256];
    logic [15:0] mem [16];
    int n = 0;
    int total = 0, bad = 0, seen = 0, ecount = 0, wait_idx = 0;

    typedef struct { int a; int d; bit f; int t; string r; } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mpe_core uut (
        .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_word(prog_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .cmp_flag(cmp_flag)
    );

    assign prog_word = rom[prog_addr];
    assign mem_rdata = mem[mem_addr[3:0]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
        if (rst) ecount <= 0; else ecount <= ecount + 1;
    end

    function automatic logic [52:0] mk(int op, int a, int b);
        return {op[4:0], a[15:0], b[15:0], 16'h0};   // R2 word layout
    endfunction

    task automatic put(int op, int a = 0, int b = 0);
        rom[n] = mk(op, a, b);
        n++;
    endtask

    task automatic check(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_wr(int a, int d, bit f, int t, string r);
        exp_t e;
        e.a = a; e.d = d; e.f = f; e.t = t; e.r = r;
        q.push_back(e);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            seen++;
            if (q.size() == 0) begin
                check(1'b0, "R7 unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(mem_addr == e.a[15:0] && mem_wdata == e.d[15:0] && cmp_flag == e.f,
                      e.r, {15'd0, cmp_flag, mem_addr, mem_wdata},
                      {15'd0, e.f, e.a[15:0], e.d[15:0]});
                if (e.t >= 0) check(ecount == e.t, {e.r, " timing"}, ecount, e.t);
            end
        end
    end

    initial begin
        int j1, j2, j3, j4, j5, le;
        for (int i = 0; i < 256; i++) rom[i] = '0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        mem[5] = 16'hBEEF;

        put(OB); put(SC,0,7); put(SC,1,5); put(SC,2,1); put(OC);          // R5
        put(OB); put(A1,0); put(A2,1); put(OC);
        put(OB); put(XA); put(OC);
        put(OB); put(RS,0,3); put(MA,2); put(OC);
        put(OB); put(MD,3); put(OC);                       expect_wr(1, 12, 0, -1, "R2 R5 R6 add");
        put(OB); put(XS); put(A1,1); put(A2,0); put(OC);   // R3: sub sees old args
        put(OB); put(RS,0,4); put(MD,0); put(OC);          expect_wr(1, 7, 0, -1, "R7 data");
        put(OB); put(MD,4); put(SC,5,2); put(OC);          expect_wr(1, 2, 0, -1, "R3 R6 sub");
        put(OB); put(MA,5); put(XM); put(OC);
        put(OB); put(RS,0,6); put(OC);
        put(OB); put(MD,6); put(OC);                       expect_wr(2, 35, 0, -1, "R6 mul");
        put(OB); put(SC,0,'h1234); put(SC,1,'h0100); put(OC);
        put(OB); put(A1,0); put(A2,1); put(OC);
        put(OB); put(XM); put(OC);
        put(OB); put(RS,0,6); put(OC);
        put(OB); put(MD,6); put(OC);                       expect_wr(2, 'h3400, 0, -1, "R6 truncation");
        put(OB); put(BB,0,1); put(BB,1,0); put(OC);
        put(OB); put(MD,1); put(OC);                       expect_wr(2, 'h1234, 0, -1, "R3 swap");
        put(OB); put(MD,0); put(OC);                       expect_wr(2, 'h0100, 0, -1, "R4 buf move");
        put(OB); put(BR,1,3); put(OC);
        put(OB); put(RB,3,7); put(SC,5,3); put(OC);
        put(OB); put(MA,5); put(MD,7); put(OC);            expect_wr(3, 'h1234, 0, -1, "R4 register");
        put(OB); put(SC,5,5); put(OC);
        put(OB); put(MA,5); put(OC);
        put(OB); put(MR,0,2); put(SC,5,6); put(OC);
        put(OB); put(MA,5); put(MD,2); put(OC);            expect_wr(6, 'hBEEF, 0, -1, "R7 read");
        put(OB); put(CE,2,'hBEEF); put(OC);
        put(OB); j1 = n; put(JP); put(OC);
        put(OB); put(MD,0); put(OC);                       // skipped by taken jump
        rom[j1] = mk(JP, n, 0);
        put(OB); put(CG,2,'hBEF0); put(OC);
        put(OB); j2 = n; put(JP); put(OC);
        put(OB); put(MD,0); put(OC);                       expect_wr(6, 'h0100, 0, -1, "R8 ge false");
        rom[j2] = mk(JP, n, 0);
        put(OB); put(CL,2,'hBEEF); put(OC);
        put(OB); j3 = n; put(JP); put(OC);
        put(OB); put(MD,1); put(OC);                       // skipped
        rom[j3] = mk(JP, n, 0);
        put(OB); put(CE,2,0); put(OC);
        put(OB); j4 = n; put(JP); put(OC);
        put(OB); put(MD,7); put(OC);                       // skipped
        rom[j4] = mk(JP, n, 1);
        put(OB); put(MD,1); put(OC);                       expect_wr(6, 'h1234, 0, -1, "R9 unconditional");
        put(OB); put(CE,2,'hBEEF); j5 = n; put(JP); put(OC);
        put(OB); put(MD,0); put(OC);                       expect_wr(6, 'h0100, 1, -1, "R9 old flag");
        rom[j5] = mk(JP, n, 0);
        put(OB); put(SC,5,7); put(OC);
        put(OB); put(MA,5); put(OC);
        put(31); put(SC,0,'h7777); put(XA);                // R11 strays outside a bundle
        put(OB); put(MD,0); put(OC);                       expect_wr(7, 'h0100, 1, -1, "R11 stray");
        wait_idx = n; put(WT,1000);
        put(OB); put(MD,1); put(OC);                       expect_wr(7, 'h1234, 1, 1004, "R10 wait");
        le = n; put(OB); put(JP,le,1); put(OC);

        repeat (3) @(negedge clk);
        check(prog_addr == 0, "R1 pc", prog_addr, 0);
        check(mem_we == 0, "R1 we", mem_we, 0);
        check(cmp_flag == 0, "R1 flag", cmp_flag, 0);
        check(mem_addr == 0, "R1 addr", mem_addr, 0);
        check(mem_wdata == 0, "R1 data", mem_wdata, 0);
        rst = 1'b0;

        for (int c = 0; c < 4000 && seen < 14; c++) @(negedge clk);
        if (seen < 14) check(1'b0, "watchdog", seen, 14);
        repeat (20) @(negedge clk);
        check(q.size() == 0 && seen == 14, "R9 write count", seen, 14);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (!rst);
        wait (ecount == 500);
        @(negedge clk);
        check(prog_addr == wait_idx[7:0], "R10 hold", prog_addr, wait_idx);
    end
endmodule